// File: doc/BRIEF.md
# Mode-Programmed DRAM Burst Sequencer

This block is the device-side control for a quad-bank mobile DDR memory. It holds the mode settings and turns each accepted READ or WRITE command into a burst. A mode-set command loads three settings from the address bus: the burst length, the order of the column addresses in a burst, and the read latency. Every later burst uses them until another mode-set command succeeds.

For each burst the block steps through the column addresses and raises a data-valid strobe for one beat per address. On reads the strobe is delayed by the programmed latency. On writes it starts on the next cycle. Commands are rejected in these cases: a mode-set with reserved codes, a mode-set while any bank is open, and an access to a bank that has not been opened. Row timing, refresh, the array and the data path are outside the block. Bank open/idle state comes in as an input vector.

Top module: `burst_seq`

## Requirements
- R1: The `cmd` encoding is 000 no-op, 010 READ, 011 WRITE, 100 mode-set, and every other value is a no-op. After reset the mode is latency 3, sequential order and length 4, and `illegal`, `busy`, `dvalid` and `col_addr` are all 0.
- R2: A mode-set with `bank`=00, all banks idle and legal codes loads the mode and clears `illegal`. The fields are `addr[2:0]` length (001=2, 010=4, 011=8), `addr[3]` order (0 sequential, 1 interleaved) and `addr[6:4]` latency (010=2, 011=3).
- R3: A mode-set with `bank`=00 while any `bank_open` bit is 1 sets `illegal` and leaves the mode unchanged.
- R4: A mode-set with `bank`=00 and a reserved length or latency code sets `illegal` and leaves the mode unchanged.
- R5: A mode-set with `bank` other than 00 changes neither the mode nor `illegal`.
- R6: A READ or WRITE to a bank whose `bank_open` bit is 0 is ignored: `busy` and `dvalid` stay 0.
- R7: When a WRITE is sampled at the end of cycle c, `dvalid` is 1 in cycles c+1 to c+BL and `busy` is 1 over the same cycles.
- R8: When a READ is sampled at the end of cycle c, `dvalid` is 1 in cycles c+CL to c+CL+BL-1 and `busy` is 1 from c+1 to the last beat.
- R9: In sequential order, beat k carries the low log2(BL) column bits (start + k) mod BL, so the address wraps inside the aligned block.
- R10: In interleaved order, beat k carries the low log2(BL) column bits start XOR k.
- R11: Any command that arrives while `busy` is 1 is ignored, including one in the last beat cycle.
- R12: In every beat, the column bits above the burst field equal those of the start column. `col_addr` is 0 whenever `dvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Decoded command |
| bank | input | 2 | Bank address |
| addr | input | 13 | Address bus |
| bank_open | input | 4 | One bit per bank, 1 when the bank is open |
| col_addr | output | 10 | Column address of the current beat |
| dvalid | output | 1 | Data-valid strobe, one beat per cycle |
| busy | output | 1 | A burst is pending or running |
| illegal | output | 1 | The last mode-set on bank 00 was rejected |

## Verification
Command acceptance and burst completion can fall in the same cycle. A new READ or mode-set can arrive during the final beat of a burst, while `busy` is still high. The bench injects a command into the middle beat and into the last beat of a running burst. It checks that the running burst finishes unchanged and that `busy` then drops and stays low. A following burst must still show the old mode settings.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10,
  parameter int NBANK  = 4,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBANK-1:0]  bank_open,
  output logic [COL_W-1:0]  col_addr,
  output logic              dvalid,
  output logic              busy,
  output logic              illegal
);
  localparam logic [2:0] C_RD  = 3'b010;
  localparam logic [2:0] C_WR  = 3'b011;
  localparam logic [2:0] C_MRS = 3'b100;

  logic [1:0]       bl_log;
  logic             bt;
  logic             cl_two;
  logic             active;
  logic [1:0]       wcnt;
  logic [2:0]       beat;
  logic [COL_W-1:0] start;

  logic [2:0] mask;
  logic [2:0] low;
  logic       is_acc, accept, mrs_hit, bl_ok, cl_ok, mrs_ok;

  assign mask    = 3'((4'd1 << bl_log) - 4'd1);
  assign is_acc  = (cmd == C_RD) || (cmd == C_WR);
  assign accept  = !active && is_acc && bank_open[bank];
  assign mrs_hit = !active && (cmd == C_MRS) && (bank == '0);
  assign bl_ok   = (addr[2:0] != 3'd0) && (addr[2:0] <= 3'd3);
  assign cl_ok   = (addr[6:4] == 3'd2) || (addr[6:4] == 3'd3);
  assign mrs_ok  = bl_ok && cl_ok && (bank_open == '0);

  assign busy   = active;
  assign dvalid = active && (wcnt == 2'd0);
  assign low    = bt ? (start[2:0] ^ beat) : (start[2:0] + beat);
  assign col_addr = dvalid ?
      {start[COL_W-1:3], (start[2:0] & ~mask) | (low & mask)} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_log  <= 2'd2;
      bt      <= 1'b0;
      cl_two  <= 1'b0;
      illegal <= 1'b0;
    end else if (mrs_hit) begin
      if (mrs_ok) begin
        bl_log  <= addr[1:0];
        bt      <= addr[3];
        cl_two  <= (addr[6:4] == 3'd2);
        illegal <= 1'b0;
      end else begin
        illegal <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      wcnt   <= 2'd0;
      beat   <= 3'd0;
      start  <= '0;
    end else if (accept) begin
      active <= 1'b1;
      wcnt   <= (cmd == C_RD) ? (cl_two ? 2'd1 : 2'd2) : 2'd0;
      beat   <= 3'd0;
      start  <= addr[COL_W-1:0];
    end else if (active) begin
      if (wcnt != 2'd0)
        wcnt <= wcnt - 2'd1;
      else if (beat == mask)
        active <= 1'b0;
      else
        beat <= beat + 3'd1;
    end
  end
endmodule

module burst_seq_chk #(
  parameter int COL_W  = 10,
  parameter int NBANK  = 4,
  localparam int BANK_W = $clog2(NBANK)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [BANK_W-1:0] bank,
  input logic [NBANK-1:0]  bank_open,
  input logic [COL_W-1:0]  col_addr,
  input logic              dvalid,
  input logic              busy,
  input logic              illegal
);
  p_write_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd == 3'b011 && bank_open[bank]) |=> (dvalid && busy));

  p_read_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd == 3'b010 && bank_open[bank]) |=> (busy && !dvalid));

  p_closed_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (cmd == 3'b010 || cmd == 3'b011) && !bank_open[bank]) |=> !busy);

  p_mrs_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd == 3'b100 && bank == '0 && (|bank_open)) |=> illegal);

  p_wait_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dvalid) |=> busy);

  p_block_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && $past(dvalid)) |-> (col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3])));
endmodule

bind burst_seq burst_seq_chk #(.COL_W(COL_W), .NBANK(NBANK)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .bank_open(bank_open),
  .col_addr(col_addr), .dvalid(dvalid), .busy(busy), .illegal(illegal));

// File: tb/test_burst_seq.sv
module test_burst_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  bank = 2'd0;
  logic [12:0] addr = '0;
  logic [3:0]  bank_open = 4'd0;
  logic [9:0]  col_addr;
  logic        dvalid, busy, illegal;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  burst_seq i_burst_seq (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .addr(addr),
    .bank_open(bank_open), .col_addr(col_addr), .dvalid(dvalid),
    .busy(busy), .illegal(illegal));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] mode(int blc, int btv, int clc);
    return {6'd0, 3'(clc), 1'(btv), 3'(blc)};
  endfunction

  task automatic send(logic [2:0] c, logic [1:0] b, logic [12:0] a);
    @(negedge clk);
    cmd = c; bank = b; addr = a;
    @(negedge clk);
    cmd = 3'd0; bank = 2'd0; addr = '0;
  endtask

  task automatic burst(string req, bit rd, logic [1:0] b, int col, int bl, int btv, int cl,
                       int inj_j, logic [2:0] inj_cmd, logic [12:0] inj_addr);
    int first, last;
    first = rd ? cl : 1;
    last  = first + bl - 1;
    @(negedge clk);
    cmd = rd ? 3'b010 : 3'b011; bank = b; addr = 13'(col);
    @(negedge clk);
    for (int j = 1; j <= last + 2; j++) begin
      cmd = 3'd0; bank = 2'd0; addr = '0;
      chk(req, $sformatf("busy cycle %0d", j), int'(busy), (j <= last) ? 1 : 0);
      chk(req, $sformatf("dvalid cycle %0d", j), int'(dvalid), (j >= first && j <= last) ? 1 : 0);
      if (j >= first && j <= last) begin
        int k, lowv, expc;
        k = j - first;
        lowv = btv ? ((col % bl) ^ k) : (((col % bl) + k) % bl);
        expc = (col - (col % bl)) + lowv;
        chk(req, $sformatf("col beat %0d", k), int'(col_addr), expc);
      end else begin
        chk("R12", "col idle", int'(col_addr), 0);
      end
      if (j == inj_j) begin
        cmd = inj_cmd; bank = 2'd0; addr = inj_addr;
      end
      @(negedge clk);
    end
    cmd = 3'd0;
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "illegal", int'(illegal), 0);
    chk("R1", "dvalid", int'(dvalid), 0);
    chk("R1", "col", int'(col_addr), 0);
    bank_open = 4'b0001;
    burst("R1 R8 R9", 1'b1, 2'd0, 37, 4, 0, 3, 0, 3'd0, '0);
    burst("R7", 1'b0, 2'd0, 38, 4, 0, 3, 0, 3'd0, '0);
    send(3'b001, 2'd0, 13'd0);
    chk("R1", "undefined code no-op busy", int'(busy), 0);
    bank_open = 4'b0000;
  endtask

  task automatic t_legal();
    send(3'b100, 2'd0, mode(3, 1, 2));
    chk("R2", "illegal after legal set", int'(illegal), 0);
    bank_open = 4'b0010;
    burst("R2 R8 R10", 1'b1, 2'd1, 19, 8, 1, 2, 0, 3'd0, '0);
    burst("R7 R10", 1'b0, 2'd1, 534, 8, 1, 2, 0, 3'd0, '0);
    bank_open = 4'b0000;
    send(3'b100, 2'd0, mode(1, 0, 3));
    bank_open = 4'b0001;
    burst("R2 R7 R9", 1'b0, 2'd0, 3, 2, 0, 3, 0, 3'd0, '0);
    burst("R8 R9", 1'b1, 2'd0, 1022, 2, 0, 3, 0, 3'd0, '0);
  endtask

  task automatic t_open_mrs();
    bank_open = 4'b0100;
    send(3'b100, 2'd0, mode(3, 1, 2));
    chk("R3", "illegal with open bank", int'(illegal), 1);
    burst("R3", 1'b1, 2'd2, 5, 2, 0, 3, 0, 3'd0, '0);
    bank_open = 4'b0000;
  endtask

  task automatic t_reserved();
    send(3'b100, 2'd0, mode(2, 0, 3));
    chk("R2", "legal set clears flag", int'(illegal), 0);
    send(3'b100, 2'd0, mode(4, 1, 2));
    chk("R4", "reserved length", int'(illegal), 1);
    send(3'b100, 2'd0, mode(2, 0, 3));
    send(3'b100, 2'd0, mode(3, 1, 1));
    chk("R4", "reserved latency", int'(illegal), 1);
    bank_open = 4'b0001;
    burst("R4", 1'b1, 2'd0, 10, 4, 0, 3, 0, 3'd0, '0);
    bank_open = 4'b0000;
  endtask

  task automatic t_bank_nz();
    send(3'b100, 2'd1, mode(3, 1, 2));
    chk("R5", "flag unchanged", int'(illegal), 1);
    bank_open = 4'b0001;
    burst("R5", 1'b0, 2'd0, 13, 4, 0, 3, 0, 3'd0, '0);
    bank_open = 4'b0000;
  endtask

  task automatic t_closed();
    bank_open = 4'b0111;
    @(negedge clk);
    cmd = 3'b010; bank = 2'd3; addr = 13'd4;
    @(negedge clk);
    cmd = 3'b011;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      cmd = 3'd0;
      chk("R6", "busy on closed bank", int'(busy), 0);
      chk("R6", "dvalid on closed bank", int'(dvalid), 0);
    end
    bank_open = 4'b0000;
  endtask

  task automatic t_busy();
    send(3'b100, 2'd0, mode(3, 0, 2));
    bank_open = 4'b0001;
    burst("R11 mid", 1'b0, 2'd0, 45, 8, 0, 2, 3, 3'b100, mode(1, 1, 3));
    burst("R11 last", 1'b1, 2'd0, 46, 8, 0, 2, 9, 3'b010, 13'd0);
    burst("R11 mode kept", 1'b1, 2'd0, 7, 8, 0, 2, 0, 3'd0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_legal();
    t_open_mrs();
    t_reserved();
    t_bank_nz();
    t_closed();
    t_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule